// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter with Clear-to-Send Gating

This block sends asynchronous serial frames on a single output line. Software-side logic writes transmit data into a holding register. The block moves that data into a separate shift register and shifts it out as a start bit, then the data bits least significant first, then an optional parity or multiprocessor bit, then one or two stop bits. Because the two registers are separate, the next value can be written while the current frame is still on the line. If the holding register was refilled in time, the next frame follows the last stop bit without an idle gap.

Two interrupt outputs pace the writer. A one-cycle request pulse says the holding register has been emptied into the shift register and can take the next value. A level end signal says the line has run out of data and gone idle. An active-low clear-to-send input, synchronised internally, holds back each transfer into the shift register until the far end is ready. A configuration bit turns that gating off. Bit timing comes from an external baud tick, and every bit lasts a fixed number of ticks.

Top module: `uart_tx_dbuf`

## Requirements
- R1: While reset is asserted, and while `tx_en` is 0, `txd` is 1 and `tx_end` is 1. `irq_req` is 0 coming out of reset, and `irq_end` is 0 whenever `tx_en` is 0.
- R2: A frame is a start bit at 0, then the data bits LSB first, then the extra bit if enabled, then the stop bits at 1. The number of data bits is set by `cfg_len`: 0 gives 7, 1 gives 8, 2 gives 9, and 3 gives 8. `cfg_two_stop`=1 selects two stop bits. Every bit lasts 16 `baud_tick` pulses.
- R3: The extra bit is sent when `cfg_par_en` or `cfg_mp_en` is 1. With `cfg_mp_en`=1 it carries `cfg_mp_bit`, whatever the parity setting. Otherwise it is the parity over the data bits only: the XOR of the data bits when `cfg_par_odd`=0 (even parity), and its inverse when `cfg_par_odd`=1.
- R4: Each transfer from the holding register into the shift register produces exactly one one-cycle `irq_req` pulse when `req_ie` is 1.
- R5: `irq_req` also pulses once when `tx_en` goes from 0 to 1 while `req_ie` is 1, including when both rise in the same cycle. Setting `req_ie` while `tx_en` is already 1 produces no pulse.
- R6: With `cts_en`=1, no transfer into the shift register starts while the synchronised `cts_n` is 1, and a pending frame starts after `cts_n` goes low. With `cts_en`=0, `cts_n` has no effect.
- R7: If the holding register has been written before the last stop bit ends, the next start bit begins right after that stop bit. Frame start times are then exactly 16 times the previous frame's bit count apart.
- R8: When the shift register reaches its stop bits and the holding register is empty, `tx_end` goes to 1 and the line stays at 1 afterwards. `irq_end` equals `tx_end` AND `end_ie` AND `tx_en`.
- R9: A `wr_lo` write marks the holding register as full and clears `tx_end`. A `wr_hi` write only stores bit 8 (from `wdata[0]`): it neither starts a frame nor clears `tx_end`.
- R10: Clearing `tx_en` in the middle of a frame makes `txd` 1 from the next cycle on and discards the rest of the frame. Re-enabling does not resume that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit |
| tx_en | input | 1 | Transmit enable |
| req_ie | input | 1 | Request interrupt enable |
| end_ie | input | 1 | End interrupt enable |
| cts_en | input | 1 | 1 = clear-to-send gating active |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| cfg_len | input | 2 | Data length code (0:7, 1:8, 2:9, 3:8) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity |
| cfg_mp_en | input | 1 | Multiprocessor bit enable |
| cfg_mp_bit | input | 1 | Multiprocessor bit value |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| wr_lo | input | 1 | Write low byte of holding register |
| wr_hi | input | 1 | Write bit 8 of holding register |
| wdata | input | 8 | Write data |
| txd | output | 1 | Serial output, idle high |
| tx_end | output | 1 | Transmit-end flag |
| irq_req | output | 1 | Transmit-request interrupt pulse |
| irq_end | output | 1 | Transmit-end interrupt level |

## Verification
The bench checks that a refilled holding register gives gapless frames, measured against start-to-start spacing. A design that decided the next transfer one bit late would show up as a lengthened spacing. It checks that a lone high-part write leaves the line idle, where a design treating it as new data would emit an unexpected frame. It checks that a blocked clear-to-send holds the frame back until release, and that a mid-frame disable drops the frame for good, where a faulty design would resume the old bits. It also covers the parity, multiprocessor and two-stop formats, the initial request pulse rules, and a slower tick rate, where a design that ignored the tick would shorten every bit.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the serial transmitter.
// Assumes data words of at most 9 bits.
package uart_tx_pkg;
    localparam int DATA_MAX = 9;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_EXTRA = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    localparam logic [1:0] LEN_7 = 2'd0;
    localparam logic [1:0] LEN_8 = 2'd1;
    localparam logic [1:0] LEN_9 = 2'd2;

    // Number of data bits for a length code (code 3 falls back to 8).
    function automatic logic [3:0] len_bits(input logic [1:0] code);
        case (code)
            LEN_7:   len_bits = 4'd7;
            LEN_9:   len_bits = 4'd9;
            default: len_bits = 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/uart_tx_cts_sync.sv
// Multi-flop synchroniser for the asynchronous clear-to-send input.
// Assumes the input is level-like; resets to the "not clear" value 1.
module uart_tx_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx_holdreg.sv
// Holding register with a full flag. A low-byte write sets the flag, and a
// high-part write only stores bit 8. A take clears the flag unless a new
// low-byte write arrives in the same cycle.
module uart_tx_holdreg
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [7:0]          wdata,
    input  logic                take,
    output logic [DATA_MAX-1:0] hold_data,
    output logic                hold_full
);
    // Store written data fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
        end else begin
            if (wr_lo) hold_data[7:0] <= wdata;
            if (wr_hi) hold_data[8]   <= wdata[0];
        end
    end

    // Track whether unsent data is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_full <= 1'b0;
        else if (wr_lo) hold_full <= 1'b1;
        else if (take)  hold_full <= 1'b0;
    end
endmodule

// File: rtl/uart_tx_extra_bit.sv
// Computes the optional bit that follows the data field: the multiprocessor
// bit when selected, else even or odd parity over the active data bits.
module uart_tx_extra_bit
    import uart_tx_pkg::*;
(
    input  logic [DATA_MAX-1:0] data,
    input  logic [1:0]          len_code,
    input  logic                par_odd,
    input  logic                mp_en,
    input  logic                mp_bit,
    output logic                extra
);
    logic [DATA_MAX-1:0] mask;
    logic                even_par;

    // Build a mask of the data bits that belong to the frame.
    always_comb begin
        for (int i = 0; i < DATA_MAX; i++) begin
            mask[i] = (i < int'(len_bits(len_code)));
        end
    end

    assign even_par = ^(data & mask);

    // Pick the multiprocessor bit or the parity bit.
    always_comb begin
        if (mp_en) extra = mp_bit;
        else       extra = even_par ^ par_odd;
    end
endmodule

// File: rtl/uart_tx_shifter.sv
// Frame sequencer and shift register. It loads from the holding register when
// idle, or at the end of the last stop bit for gapless frames, whenever data
// is waiting and clear-to-send allows. The frame format is latched at load
// time. Assumes baud_tick is a one-cycle pulse.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                baud_tick,
    input  logic                hold_full,
    input  logic [DATA_MAX-1:0] hold_data,
    input  logic                cts_ok,
    input  logic [1:0]          len_code,
    input  logic                extra_en,
    input  logic                extra_val,
    input  logic                two_stop,
    output logic                load,
    output logic                stop_entry,
    output logic                txd
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] TLAST = CW'(OVS - 1);

    tx_state_e           state_q;
    logic [CW-1:0]       tcnt_q;
    logic [3:0]          bcnt_q;
    logic [DATA_MAX-1:0] sr_q;
    logic [3:0]          nbits_q;
    logic                ext_en_q;
    logic                ext_v_q;
    logic                two_q;
    logic                bit_end;

    assign bit_end = baud_tick && (tcnt_q == TLAST);

    // Decide a transfer from the holding register.
    always_comb begin
        load = 1'b0;
        if (tx_en && hold_full && cts_ok) begin
            if (state_q == ST_IDLE) load = 1'b1;
            else if (state_q == ST_STOP && bit_end && bcnt_q == 4'd0) load = 1'b1;
        end
    end

    // Flag the cycle in which the sequencer moves into the stop bits.
    always_comb begin
        stop_entry = 1'b0;
        if (tx_en && bit_end) begin
            if (state_q == ST_DATA && bcnt_q == 4'd0 && !ext_en_q) stop_entry = 1'b1;
            if (state_q == ST_EXTRA) stop_entry = 1'b1;
        end
    end

    // Oversampling tick counter within one bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en || load || state_q == ST_IDLE) tcnt_q <= '0;
        else if (baud_tick) tcnt_q <= bit_end ? '0 : tcnt_q + 1'b1;
    end

    // Frame state, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bcnt_q   <= '0;
            sr_q     <= '0;
            nbits_q  <= 4'd8;
            ext_en_q <= 1'b0;
            ext_v_q  <= 1'b0;
            two_q    <= 1'b0;
        end else if (!tx_en) begin
            state_q <= ST_IDLE;
        end else if (load) begin
            state_q  <= ST_START;
            sr_q     <= hold_data;
            nbits_q  <= len_bits(len_code);
            ext_en_q <= extra_en;
            ext_v_q  <= extra_val;
            two_q    <= two_stop;
        end else if (bit_end) begin
            case (state_q)
                ST_START: begin
                    state_q <= ST_DATA;
                    bcnt_q  <= nbits_q - 4'd1;
                end
                ST_DATA: begin
                    sr_q <= sr_q >> 1;
                    if (bcnt_q == 4'd0) begin
                        if (ext_en_q) begin
                            state_q <= ST_EXTRA;
                        end else begin
                            state_q <= ST_STOP;
                            bcnt_q  <= {3'b000, two_q};
                        end
                    end else begin
                        bcnt_q <= bcnt_q - 4'd1;
                    end
                end
                ST_EXTRA: begin
                    state_q <= ST_STOP;
                    bcnt_q  <= {3'b000, two_q};
                end
                ST_STOP: begin
                    if (bcnt_q == 4'd0) state_q <= ST_IDLE;
                    else                bcnt_q  <= bcnt_q - 4'd1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the line from the current frame position.
    always_comb begin
        case (state_q)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = sr_q[0];
            ST_EXTRA: txd = ext_v_q;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_dbuf.sv
// Top of the double-buffered transmitter: holding register, clear-to-send
// synchroniser, extra-bit logic, frame sequencer, transmit-end flag and the
// two interrupt outputs. Assumes configuration is stable while enabled.
module uart_tx_dbuf
    import uart_tx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       tx_en,
    input  logic       req_ie,
    input  logic       end_ie,
    input  logic       cts_en,
    input  logic       cts_n,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_mp_en,
    input  logic       cfg_mp_bit,
    input  logic       cfg_two_stop,
    input  logic       wr_lo,
    input  logic       wr_hi,
    input  logic [7:0] wdata,
    output logic       txd,
    output logic       tx_end,
    output logic       irq_req,
    output logic       irq_end
);
    logic [DATA_MAX-1:0] hold_data_w;
    logic                hold_full_w;
    logic                load_w;
    logic                stop_entry_w;
    logic                cts_sync_w;
    logic                cts_ok_w;
    logic                extra_w;
    logic                tx_en_d;
    logic                tend_q;
    logic                irq_req_q;

    uart_tx_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cts_n), .sync_out(cts_sync_w)
    );

    assign cts_ok_w = !cts_en || !cts_sync_w;

    uart_tx_holdreg u_hold (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
        .take(load_w), .hold_data(hold_data_w), .hold_full(hold_full_w)
    );

    uart_tx_extra_bit u_extra (
        .data(hold_data_w), .len_code(cfg_len), .par_odd(cfg_par_odd),
        .mp_en(cfg_mp_en), .mp_bit(cfg_mp_bit), .extra(extra_w)
    );

    uart_tx_shifter #(.OVS(OVS)) u_sh (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
        .hold_full(hold_full_w), .hold_data(hold_data_w), .cts_ok(cts_ok_w),
        .len_code(cfg_len), .extra_en(cfg_par_en || cfg_mp_en),
        .extra_val(extra_w), .two_stop(cfg_two_stop),
        .load(load_w), .stop_entry(stop_entry_w), .txd(txd)
    );

    // Transmit-end flag: forced while disabled, cleared by data, set at stop time when empty.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en)                  tend_q <= 1'b1;
        else if (wr_lo)                        tend_q <= 1'b0;
        else if (stop_entry_w && !hold_full_w) tend_q <= 1'b1;
    end

    // Request pulse on enable rise or on each transfer into the shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_d   <= 1'b0;
            irq_req_q <= 1'b0;
        end else begin
            tx_en_d   <= tx_en;
            irq_req_q <= req_ie && ((tx_en && !tx_en_d) || load_w);
        end
    end

    assign tx_end  = tend_q;
    assign irq_req = irq_req_q;
    assign irq_end = tend_q && end_ie && tx_en;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
// Property checker for uart_tx_dbuf, attached by bind below.
module uart_tx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic end_ie,
    input logic wr_lo,
    input logic txd,
    input logic tx_end,
    input logic irq_end,
    input logic load,
    input logic hold_full,
    input logic cts_en,
    input logic cts_sync
);
    // R1 / R10: a disabled transmitter drives the line idle high from the next cycle.
    a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd);

    // R1: the end flag reads 1 after a disabled cycle.
    a_r1_end_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> tx_end);

    // R9: a low-byte write while enabled clears the end flag.
    a_r9_write_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && wr_lo) |=> !tx_end);

    // R2: a transfer is followed by the start bit at 0.
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd);

    // R9: only waiting data is transferred.
    a_r9_load_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> hold_full);

    // R6: a blocked clear-to-send prevents any transfer.
    a_r6_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_en && cts_sync) |-> !load);

    // R8: the end interrupt only with the flag and its enable.
    a_r8_end_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end |-> (tx_end && end_ie && tx_en));
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .end_ie(end_ie), .wr_lo(wr_lo),
    .txd(txd), .tx_end(tx_end), .irq_end(irq_end), .load(load_w),
    .hold_full(hold_full_w), .cts_en(cts_en), .cts_sync(cts_sync_w)
);

// File: tb/uart_tx_dbuf_tb_top.sv
// Scoreboard bench: the driver pushes expected frames, the monitor decodes the line.
module uart_tx_dbuf_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b1;
    logic tx_en = 1'b0, req_ie = 1'b0, end_ie = 1'b0;
    logic cts_en = 1'b0, cts_n = 1'b1;
    logic [1:0] cfg_len = 2'd1;
    logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_mp_en = 1'b0, cfg_mp_bit = 1'b0;
    logic cfg_two_stop = 1'b0;
    logic wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic txd, tx_end, irq_req, irq_end;

    always #2.5 clk = ~clk;

    uart_tx_dbuf dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .req_ie(req_ie), .end_ie(end_ie), .cts_en(cts_en), .cts_n(cts_n),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_mp_en(cfg_mp_en), .cfg_mp_bit(cfg_mp_bit), .cfg_two_stop(cfg_two_stop),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
        .txd(txd), .tx_end(tx_end), .irq_req(irq_req), .irq_end(irq_end)
    );

    typedef struct {
        logic [15:0] bits;
        int          n;
        bit          gapless;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int  n_checks = 0, n_errors = 0;
    int  cyc = 0, irq_cnt = 0, div = 1;
    bit  mon_on = 1'b1, mon_busy = 1'b0;
    int  last_start = 0, last_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Tick generator: every cycle or every div cycles, changed away from the edge.
    always @(negedge clk) baud_tick <= (div == 1) ? 1'b1 : ((cyc % div) == 0);

    // Count request pulses.
    always @(negedge clk) if (irq_req) irq_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Expected frame built from the format rules.
    function automatic item_t build(input logic [8:0] d, input bit gl, input string tag);
        item_t it;
        int nd, k;
        logic par;
        nd = (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd2) ? 9 : 8;
        it.bits = '0;
        k = 1;
        par = 1'b0;
        for (int i = 0; i < nd; i++) begin
            it.bits[k] = d[i];
            par ^= d[i];
            k++;
        end
        if (cfg_mp_en) begin
            it.bits[k] = cfg_mp_bit; k++;
        end else if (cfg_par_en) begin
            it.bits[k] = par ^ cfg_par_odd; k++;
        end
        it.bits[k] = 1'b1; k++;
        if (cfg_two_stop) begin
            it.bits[k] = 1'b1; k++;
        end
        it.n = k;
        it.gapless = gl;
        it.tag = tag;
        return it;
    endfunction

    // Driver: push the expected frame, then write the data.
    task automatic send(input logic [8:0] d, input bit gl, input string tag, input bit push);
        if (push) exp_q.push_back(build(d, gl, tag));
        if (cfg_len == 2'd2) begin
            @(negedge clk); wr_hi = 1'b1; wdata = {7'b0, d[8]};
            @(negedge clk); wr_hi = 1'b0;
        end else begin
            @(negedge clk);
        end
        wr_lo = 1'b1; wdata = d[7:0];
        @(negedge clk); wr_lo = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0 || mon_busy) @(negedge clk);
        repeat (16 * div + 4) @(negedge clk);
    endtask

    // Monitor: detect start bits, sample mid-bit, compare with the queue.
    always begin
        @(negedge clk);
        if (mon_on && txd === 1'b0) begin
            item_t it;
            int st;
            mon_busy = 1'b1;
            st = cyc;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected frame", 1, 0);
                repeat (16 * div * 12) @(negedge clk);
            end else begin
                it = exp_q.pop_front();
                if (it.gapless)
                    chk(st - last_start == 16 * last_n, "R7 gapless spacing",
                        st - last_start, 16 * last_n);
                repeat (8 * div) @(negedge clk);
                for (int k = 0; k < it.n; k++) begin
                    chk(txd === it.bits[k], it.tag, int'(txd), int'(it.bits[k]));
                    if (k < it.n - 1) repeat (16 * div) @(negedge clk);
                end
                last_start = st;
                last_n = it.n;
            end
            mon_busy = 1'b0;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int c0;
        int lows;
        end_ie = 1'b1;
        repeat (4) @(negedge clk);
        chk(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
        chk(tx_end === 1'b1, "R1 tx_end in reset", int'(tx_end), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_req === 1'b0, "R1 irq_req after reset", int'(irq_req), 0);
        chk(irq_end === 1'b0, "R1 irq_end while disabled", int'(irq_end), 0);

        // R5: both enables rise together.
        req_ie = 1'b1; tx_en = 1'b1;
        @(negedge clk);
        chk(irq_req === 1'b1, "R5 initial request pulse", int'(irq_req), 1);
        @(negedge clk);
        chk(irq_req === 1'b0, "R5 pulse is one cycle", int'(irq_req), 0);
        chk(irq_end === 1'b1, "R8 idle end interrupt", int'(irq_end), 1);

        // R5: request enable set after transmit enable, so no pulse.
        tx_en = 1'b0; req_ie = 1'b0;
        @(negedge clk); tx_en = 1'b1;
        @(negedge clk); c0 = irq_cnt; req_ie = 1'b1;
        repeat (5) @(negedge clk);
        chk(irq_cnt == c0, "R5 no pulse on late enable", irq_cnt, c0);

        // R2 / R4 / R8: plain 8-bit frame.
        c0 = irq_cnt;
        send(9'h0A5, 0, "R2 8N1 frame", 1);
        wait_done();
        chk(irq_cnt == c0 + 1, "R4 one pulse per transfer", irq_cnt, c0 + 1);
        chk(tx_end === 1'b1, "R8 end flag after last frame", int'(tx_end), 1);
        chk(irq_end === 1'b1, "R8 end interrupt", int'(irq_end), 1);

        // R3: parity and multiprocessor formats.
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(9'h05B, 0, "R3 7-bit even parity", 1); wait_done();
        cfg_len = 2'd1; cfg_par_odd = 1'b1;
        send(9'h03C, 0, "R3 8-bit odd parity", 1); wait_done();
        cfg_len = 2'd2; cfg_par_en = 1'b0; cfg_mp_en = 1'b1; cfg_mp_bit = 1'b1; cfg_two_stop = 1'b1;
        send(9'h1A5, 0, "R2 9-bit mp two stop", 1); wait_done();
        cfg_len = 2'd1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_mp_bit = 1'b0; cfg_two_stop = 1'b0;
        send(9'h007, 0, "R3 mp bit overrides parity", 1); wait_done();
        cfg_par_en = 1'b0; cfg_mp_en = 1'b0;

        // R6 / R9: blocked clear-to-send, write clears the end flag.
        cts_en = 1'b1; cts_n = 1'b1;
        send(9'h081, 0, "R6 frame after release", 1);
        @(negedge clk);
        chk(tx_end === 1'b0, "R9 write clears end flag", int'(tx_end), 0);
        lows = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk(lows == 0, "R6 blocked by cts", lows, 0);
        chk(exp_q.size() == 1, "R6 frame still pending", exp_q.size(), 1);
        cts_n = 1'b0;
        wait_done();
        cts_n = 1'b1; cts_en = 1'b0;
        send(9'h042, 0, "R6 cts bypass", 1); wait_done();

        // R7: back-to-back frames.
        c0 = irq_cnt;
        send(9'h011, 0, "R7 first frame", 1);
        while (irq_cnt == c0) @(negedge clk);
        send(9'h022, 1, "R7 second frame", 1);
        while (irq_cnt == c0 + 1) @(negedge clk);
        send(9'h033, 1, "R7 third frame", 1);
        wait_done();

        // R9: high-part write alone starts nothing.
        cfg_len = 2'd2;
        @(negedge clk); wr_hi = 1'b1; wdata = 8'h01;
        @(negedge clk); wr_hi = 1'b0;
        lows = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk(lows == 0, "R9 high write alone idle", lows, 0);
        chk(tx_end === 1'b1, "R9 high write keeps end flag", int'(tx_end), 1);
        cfg_len = 2'd1;

        // R10: disable in mid-frame.
        mon_on = 1'b0; req_ie = 1'b0;
        send(9'h0F0, 0, "", 0);
        repeat (40) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R10 line idles at once", int'(txd), 1);
        chk(tx_end === 1'b1, "R10 end flag when disabled", int'(tx_end), 1);
        tx_en = 1'b1;
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk(lows == 0, "R10 frame not resumed", lows, 0);
        mon_on = 1'b1;

        // R2: slower tick rate.
        div = 2;
        send(9'h096, 0, "R2 slow tick frame", 1); wait_done();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule